// File: doc/BRIEF.md
# Load Alignment and Extension Unit

This unit sits in the load path of a 32-bit RISC core. It takes a load operation together with a base register value, a signed 16-bit displacement and a destination register index. From these it forms the effective address and checks that the address is naturally aligned for the access width. It then either raises an address-error-on-load or issues one read request to a simple request/response memory port.

When the read response comes back, the unit picks the addressed byte or halfword out of the returned 32-bit word in big-endian lane order. It sign- or zero-extends that value and produces a single-cycle register write. A response flagged as an error produces no write.

The load-linked word operation also sets a link flag when it is accepted. The flag is cleared if its memory access returns an error. The unit handles one load at a time and refuses new work until the outstanding response has arrived.

Top module: `load_align_unit`

## Requirements
- R1: The effective address equals `rs_val_i` plus the sign-extended `offset_i`. For an aligned load it appears on `mem_addr_o`, with `mem_req_o` high for exactly one cycle, on the clock edge after the load is accepted.
- R2: `mem_size_o` is 0 for byte loads, 1 for halfword loads and 2 for the load-linked word. Operation codes on `op_i` are: 0 signed byte, 1 unsigned byte, 2 signed halfword, 3 unsigned halfword, 4 load-linked word.
- R3: A halfword load whose effective address has bit 0 set raises `exc_o` for one cycle and places the effective address on `bad_addr_o`. No memory request is issued and the unit stays ready.
- R4: A load-linked word whose effective address has bit 1 or bit 0 set raises `exc_o`, updates `bad_addr_o` and issues no request.
- R5: A byte load selects lane `addr[1:0]`, where lane 0 is bits 31:24 and lane 3 is bits 7:0. The signed byte load sign-extends the byte from bit 7; the unsigned byte load zero-extends it.
- R6: A halfword load selects bits 31:16 when `addr[1]` is 0 and bits 15:0 otherwise. The signed halfword load sign-extends from bit 15; the unsigned halfword load zero-extends.
- R7: `link_o` is set on the edge that accepts an aligned load-linked word. It is cleared on the edge that takes an error response for that load. It is unchanged by any other load and by a misaligned load-linked word.
- R8: `ready_o` is low from acceptance until the edge that takes the response. While it is low, `req_valid_i` is ignored and no further request is issued.
- R9: A successful response produces `wb_en_o` for one cycle, with `wb_reg_o` set to the load's destination and `wb_data_o` set to the formatted value. An error response produces no write.
- R10: Operation codes 5 to 7 are ignored: no request, no exception, and the unit stays ready.
- R11: After reset `ready_o` is 1, and `mem_req_o`, `wb_en_o`, `exc_o` and `link_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Load request valid |
| op_i | input | 3 | Load operation code |
| rs_val_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| dest_i | input | 5 | Destination register index |
| ready_o | output | 1 | Unit idle and able to accept a load |
| mem_req_o | output | 1 | Memory read request strobe |
| mem_addr_o | output | 32 | Memory read address |
| mem_size_o | output | 2 | Access size code |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rsp_data_i | input | 32 | Memory read word |
| mem_rsp_err_i | input | 1 | Memory response error |
| wb_en_o | output | 1 | Register write strobe |
| wb_reg_o | output | 5 | Register write index |
| wb_data_o | output | 32 | Register write data |
| exc_o | output | 1 | Address-error-on-load strobe |
| bad_addr_o | output | 32 | Faulting effective address |
| link_o | output | 1 | Load-link flag |

## Verification
Two events can fall in the same cycle: the arrival of a memory response and the presentation of a new load. The bench provokes this by driving `req_valid_i` with a valid operation in exactly the cycle the response is delivered. It then judges that the new load was dropped: no second request appears, and the write-back carries the first load's destination and data. A second collision is between an error response for a load-linked word and the link flag. The bench checks that the flag drops on the same edge that suppresses the write.

// File: rtl/load_pkg.sv
package load_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned OFF_W = 16;
  localparam int unsigned RIDX_W = 5;

  typedef enum logic [2:0] {
    OP_BYTE_S = 3'd0,
    OP_BYTE_U = 3'd1,
    OP_HALF_S = 3'd2,
    OP_HALF_U = 3'd3,
    OP_LINK_W = 3'd4
  } ld_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } ld_size_e;
endpackage

// File: rtl/ld_addr_check.sv
module ld_addr_check
  import load_pkg::*;
#(
  parameter int unsigned AW = XLEN,
  parameter int unsigned OW = OFF_W
) (
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] off_i,
  output logic [AW-1:0] ea_o,
  output logic          known_o,
  output logic          misalign_o,
  output ld_size_e      size_o
);
  localparam int unsigned EXT_W = AW - OW;

  assign ea_o = base_i + {{EXT_W{off_i[OW-1]}}, off_i};

  always_comb begin
    known_o    = 1'b1;
    misalign_o = 1'b0;
    size_o     = SZ_BYTE;
    unique case (op_i)
      OP_BYTE_S, OP_BYTE_U: size_o = SZ_BYTE;
      OP_HALF_S, OP_HALF_U: begin
        size_o     = SZ_HALF;
        misalign_o = ea_o[0];
      end
      OP_LINK_W: begin
        size_o     = SZ_WORD;
        misalign_o = |ea_o[1:0];
      end
      default: known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ld_extend.sv
module ld_extend
  import load_pkg::*;
#(
  parameter int unsigned DW = XLEN
) (
  input  logic [2:0]    op_i,
  input  logic [1:0]    lane_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] data_o
);
  localparam int unsigned BW = 8;
  localparam int unsigned HW = 16;

  logic [BW-1:0] byte_sel;
  logic [HW-1:0] half_sel;

  // big-endian: lane 0 is the most significant byte
  always_comb begin
    unique case (lane_i)
      2'd0:    byte_sel = word_i[31:24];
      2'd1:    byte_sel = word_i[23:16];
      2'd2:    byte_sel = word_i[15:8];
      default: byte_sel = word_i[7:0];
    endcase
    half_sel = lane_i[1] ? word_i[15:0] : word_i[31:16];
  end

  always_comb begin
    unique case (op_i)
      OP_BYTE_S: data_o = {{(DW-BW){byte_sel[BW-1]}}, byte_sel};
      OP_BYTE_U: data_o = {{(DW-BW){1'b0}}, byte_sel};
      OP_HALF_S: data_o = {{(DW-HW){half_sel[HW-1]}}, half_sel};
      OP_HALF_U: data_o = {{(DW-HW){1'b0}}, half_sel};
      default:   data_o = word_i;
    endcase
  end
endmodule

// File: rtl/load_align_unit.sv
module load_align_unit
  import load_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [2:0]  op_i,
  input  logic [31:0] rs_val_i,
  input  logic [15:0] offset_i,
  input  logic [4:0]  dest_i,
  output logic        ready_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  output logic [1:0]  mem_size_o,
  input  logic        mem_rsp_valid_i,
  input  logic [31:0] mem_rsp_data_i,
  input  logic        mem_rsp_err_i,
  output logic        wb_en_o,
  output logic [4:0]  wb_reg_o,
  output logic [31:0] wb_data_o,
  output logic        exc_o,
  output logic [31:0] bad_addr_o,
  output logic        link_o
);
  logic [XLEN-1:0] ea;
  logic            known, misalign;
  ld_size_e        size;
  logic [XLEN-1:0] fmt_data;

  logic              busy_q, req_q, exc_q, wb_q, link_q;
  logic [XLEN-1:0]   addr_q, bad_q, wbd_q;
  logic [1:0]        size_q;
  logic [2:0]        op_q;
  logic [1:0]        lane_q;
  logic [RIDX_W-1:0] dest_q, wbr_q;

  ld_addr_check #(.AW(XLEN), .OW(OFF_W)) u_addr (
    .op_i      (op_i),
    .base_i    (rs_val_i),
    .off_i     (offset_i),
    .ea_o      (ea),
    .known_o   (known),
    .misalign_o(misalign),
    .size_o    (size)
  );

  ld_extend #(.DW(XLEN)) u_ext (
    .op_i  (op_q),
    .lane_i(lane_q),
    .word_i(mem_rsp_data_i),
    .data_o(fmt_data)
  );

  logic accept, rsp_take;
  assign accept   = req_valid_i && !busy_q && known;
  assign rsp_take = busy_q && mem_rsp_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      exc_q  <= 1'b0;
      wb_q   <= 1'b0;
      link_q <= 1'b0;
      addr_q <= '0;
      bad_q  <= '0;
      wbd_q  <= '0;
      size_q <= '0;
      op_q   <= '0;
      lane_q <= '0;
      dest_q <= '0;
      wbr_q  <= '0;
    end else begin
      req_q <= 1'b0;
      exc_q <= 1'b0;
      wb_q  <= 1'b0;
      if (accept) begin
        if (misalign) begin
          exc_q <= 1'b1;
          bad_q <= ea;
        end else begin
          req_q  <= 1'b1;
          busy_q <= 1'b1;
          addr_q <= ea;
          size_q <= size;
          op_q   <= op_i;
          lane_q <= ea[1:0];
          dest_q <= dest_i;
          if (op_i == OP_LINK_W) link_q <= 1'b1;
        end
      end
      if (rsp_take) begin
        busy_q <= 1'b0;
        if (mem_rsp_err_i) begin
          if (op_q == OP_LINK_W) link_q <= 1'b0;
        end else begin
          wb_q  <= 1'b1;
          wbd_q <= fmt_data;
          wbr_q <= dest_q;
        end
      end
    end
  end

  assign ready_o    = !busy_q;
  assign mem_req_o  = req_q;
  assign mem_addr_o = addr_q;
  assign mem_size_o = size_q;
  assign wb_en_o    = wb_q;
  assign wb_reg_o   = wbr_q;
  assign wb_data_o  = wbd_q;
  assign exc_o      = exc_q;
  assign bad_addr_o = bad_q;
  assign link_o     = link_q;
endmodule

// File: rtl/load_align_checker.sv
module load_align_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ready_o,
  input logic        mem_req_o,
  input logic        mem_rsp_valid_i,
  input logic        mem_rsp_err_i,
  input logic        wb_en_o,
  input logic        exc_o,
  input logic        link_o
);
  // R3, R4: a fault never coincides with a request or a write
  p_one_event_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({exc_o, mem_req_o, wb_en_o}));

  // R8: a request leaves the unit busy
  p_req_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o);

  // R9: an error response is followed by no write
  p_err_no_wb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && mem_rsp_valid_i && mem_rsp_err_i) |=> !wb_en_o);

  // R7: link drops only after an error response
  p_link_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_o) |-> $past(mem_rsp_valid_i && mem_rsp_err_i && !ready_o));

  // R7: link rises only together with a request
  p_link_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_o) |-> mem_req_o);
endmodule

bind load_align_unit load_align_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ready_o        (ready_o),
  .mem_req_o      (mem_req_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .mem_rsp_err_i  (mem_rsp_err_i),
  .wb_en_o        (wb_en_o),
  .exc_o          (exc_o),
  .link_o         (link_o)
);

// File: tb/load_align_unit_bench.sv
module load_align_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [15:0] offset_i = '0;
  logic [4:0]  dest_i = '0;
  logic        ready_o, mem_req_o, wb_en_o, exc_o, link_o;
  logic [31:0] mem_addr_o, wb_data_o, bad_addr_o;
  logic [1:0]  mem_size_o;
  logic [4:0]  wb_reg_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        mem_rsp_err_i = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  load_align_unit u_load_align_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [31:0] rs,
                       input logic [15:0] off, input logic [4:0] d);
    req_valid_i = 1'b1; op_i = op; rs_val_i = rs; offset_i = off; dest_i = d;
    @(posedge clk_i); @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic respond(input logic [31:0] data, input logic err);
    mem_rsp_valid_i = 1'b1; mem_rsp_data_i = data; mem_rsp_err_i = err;
    @(posedge clk_i); @(negedge clk_i);
    mem_rsp_valid_i = 1'b0; mem_rsp_err_i = 1'b0;
  endtask

  // full aligned load with success response
  task automatic t_load(input string tag, input logic [2:0] op, input logic [31:0] rs,
                        input logic [15:0] off, input logic [31:0] word,
                        input logic [1:0] exp_sz, input logic [31:0] exp_data);
    logic [31:0] ea;
    ea = rs + {{16{off[15]}}, off};
    issue(op, rs, off, 5'd9);
    chk({tag, " R1 req"}, {31'd0, mem_req_o}, 32'd1);
    chk({tag, " R1 addr"}, mem_addr_o, ea);
    chk({tag, " R2 size"}, {30'd0, mem_size_o}, {30'd0, exp_sz});
    chk({tag, " R8 busy"}, {31'd0, ready_o}, 32'd0);
    respond(word, 1'b0);
    chk({tag, " R9 wb"}, {31'd0, wb_en_o}, 32'd1);
    chk({tag, " R9 reg"}, {27'd0, wb_reg_o}, 32'd9);
    chk({tag, " data"}, wb_data_o, exp_data);
    chk({tag, " R8 ready"}, {31'd0, ready_o}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R11 ready", {31'd0, ready_o}, 32'd1);
    chk("R11 req", {31'd0, mem_req_o}, 32'd0);
    chk("R11 wb", {31'd0, wb_en_o}, 32'd0);
    chk("R11 exc", {31'd0, exc_o}, 32'd0);
    chk("R11 link", {31'd0, link_o}, 32'd0);
  endtask

  task automatic t_extend();
    t_load("R5 sbyte", 3'd0, 32'h1000, 16'hFFFE, 32'h1122_8344, 2'd0, 32'hFFFF_FF83);
    t_load("R5 ubyte", 3'd1, 32'h1000, 16'hFFFE, 32'h1122_8344, 2'd0, 32'h0000_0083);
    t_load("R5 ubyte lane0", 3'd1, 32'h2000, 16'h0000, 32'hA5_00_00_00, 2'd0, 32'h0000_00A5);
    t_load("R6 shalf lo", 3'd2, 32'h2000, 16'h0002, 32'h0000_9ABC, 2'd1, 32'hFFFF_9ABC);
    t_load("R6 uhalf lo", 3'd3, 32'h2000, 16'h0002, 32'h0000_9ABC, 2'd1, 32'h0000_9ABC);
    t_load("R6 shalf hi", 3'd2, 32'h2000, 16'h0000, 32'h7654_FFFF, 2'd1, 32'h0000_7654);
  endtask

  task automatic t_misalign();
    issue(3'd2, 32'h3000, 16'h0001, 5'd3);
    chk("R3 exc", {31'd0, exc_o}, 32'd1);
    chk("R3 bad", bad_addr_o, 32'h3001);
    chk("R3 no req", {31'd0, mem_req_o}, 32'd0);
    chk("R3 ready", {31'd0, ready_o}, 32'd1);
    issue(3'd4, 32'h4002, 16'h0000, 5'd3);
    chk("R4 exc", {31'd0, exc_o}, 32'd1);
    chk("R4 bad", bad_addr_o, 32'h4002);
    chk("R4 no req", {31'd0, mem_req_o}, 32'd0);
    chk("R7 link unchanged", {31'd0, link_o}, 32'd0);
  endtask

  task automatic t_link();
    issue(3'd4, 32'h4000, 16'h0010, 5'd4);
    chk("R7 link set", {31'd0, link_o}, 32'd1);
    chk("R2 word size", {30'd0, mem_size_o}, 32'd2);
    respond(32'hDEAD_BEEF, 1'b0);
    chk("R9 ll data", wb_data_o, 32'hDEAD_BEEF);
    chk("R7 link held", {31'd0, link_o}, 32'd1);
    // byte error: no write, link kept
    issue(3'd0, 32'h5000, 16'h0000, 5'd6);
    respond(32'hFFFF_FFFF, 1'b1);
    chk("R9 err no wb", {31'd0, wb_en_o}, 32'd0);
    chk("R7 link kept", {31'd0, link_o}, 32'd1);
    // ll error: link cleared on the same edge
    issue(3'd4, 32'h4000, 16'h0000, 5'd4);
    respond(32'h1234_5678, 1'b1);
    chk("R7 link cleared", {31'd0, link_o}, 32'd0);
    chk("R9 ll err no wb", {31'd0, wb_en_o}, 32'd0);
  endtask

  task automatic t_busy();
    issue(3'd1, 32'h6000, 16'h0003, 5'd7);
    // new load while busy
    issue(3'd1, 32'h7000, 16'h0000, 5'd8);
    chk("R8 no second req", {31'd0, mem_req_o}, 32'd0);
    chk("R8 still busy", {31'd0, ready_o}, 32'd0);
    // collision: new load in the response cycle
    req_valid_i = 1'b1; op_i = 3'd1; rs_val_i = 32'h7000; dest_i = 5'd8;
    respond(32'h0000_00C3, 1'b0);
    req_valid_i = 1'b0;
    chk("R8 wb dest first", {27'd0, wb_reg_o}, 32'd7);
    chk("R5 wb data lane3", wb_data_o, 32'h0000_00C3);
    chk("R8 dropped req", {31'd0, mem_req_o}, 32'd0);
    @(posedge clk_i); @(negedge clk_i);
    chk("R8 no late req", {31'd0, mem_req_o}, 32'd0);
  endtask

  task automatic t_illegal();
    for (int k = 5; k < 8; k++) begin
      issue(k[2:0], 32'h8001, 16'h0000, 5'd1);
      chk("R10 no req", {31'd0, mem_req_o}, 32'd0);
      chk("R10 no exc", {31'd0, exc_o}, 32'd0);
      chk("R10 ready", {31'd0, ready_o}, 32'd1);
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_extend();
    t_misalign();
    t_link();
    t_busy();
    t_illegal();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule